// File: doc/BRIEF.md
# Presettable Synchronous Decimal Counter Chain

This block is a cascadable binary-coded-decimal counter. Each digit holds a 4-bit value that steps from 0 through 9 and back to 0. A digit can be preset from a 4-bit data input. It has two count enables: a shared "step" enable and a per-digit "carry-in" enable. Only the carry-in enable takes part in forming the digit's terminal-count flag. The terminal-count flag is a combinational function of the digit state and its carry-in. Because of that, the next digit can use the flag directly as its own carry-in, and every digit looks ahead in the same clock cycle without extra gating.

The top level chains a parameterised number of digits to form a multi-digit synchronous decimal counter.
- The global load and step enables drive every digit.
- The global carry-in feeds only the least significant digit.
- Each digit's terminal count feeds the carry-in of the digit above it.
- The last digit's terminal count is the chain's terminal count.

An active-low clear acts asynchronously and overrides everything. All other state changes happen on the rising clock edge.

Top module: `bcd_chain`

## Requirements
- R1: While `clr_n` is low, every digit value and every terminal-count output is 0 at once, without waiting for a clock edge. Rising clock edges while `clr_n` is low change nothing.
- R2: When `load_n` is low at a rising edge, digit k takes `load_data[4k+3:4k]`, whatever the levels of `step_en` and `carry_in`.
- R3: When `load_n` is high, a digit advances one step at a rising edge only if `step_en` and that digit's carry-in are both high. Otherwise it keeps its value.
- R4: A count step from 9 gives 0.
- R5: A count step from a loaded code 10 to 14 gives that code plus one, and a step from 15 gives 0. Any digit therefore reaches a decimal value within six steps.
- R6: A digit's terminal count (`digit_tc[k]`) is high exactly when its value is 9 (binary 1001) and its carry-in is high. It follows changes of the carry-in combinationally, within the same cycle.
- R7: The carry-in of digit 0 is `carry_in`, and the carry-in of digit k>0 is `digit_tc[k-1]`. `chain_tc` equals `digit_tc[DIGITS-1]`. A full chain therefore rolls from all nines to all zeros in one edge.
- R8: After `clr_n` returns high, the first rising edge acts normally: it loads or counts as R2 and R3 require.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous preset, active low, shared by all digits |
| step_en | input | 1 | Count enable shared by all digits |
| carry_in | input | 1 | Carry-in enable of the least significant digit |
| load_data | input | DIGITS*4 | Preset values, digit k in bits 4k+3:4k |
| count_out | output | DIGITS*4 | Digit values, digit k in bits 4k+3:4k |
| digit_tc | output | DIGITS | Terminal count of each digit |
| chain_tc | output | 1 | Terminal count of the whole chain |

## Verification
A digit that holds the wrong value shows up on `count_out` at the next sample, because the value is a register driven straight to the port. A wrong carry path is less direct. It shows on `digit_tc` at once, but on the higher digits only at the first edge where a lower digit passes through 9. For this reason the bench walks lower digits through 9 with carry-in both high and low. An invalid-code or wrap-around fault becomes visible only after loading codes 10 to 15, so the bench steps one digit from 10 through 15 to 0. Each such step is compared one edge after it happens.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] TOP_CODE = 4'd9;

  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_COUNT = 2'd1,
    STEP_LOAD  = 2'd2
  } step_mode_t;
endpackage

// File: rtl/bcd_mode_dec.sv
module bcd_mode_dec
  import bcd_pkg::*;
(
  input  logic       load_n,
  input  logic       step_en,
  input  logic       cin,
  output step_mode_t mode
);
  // load wins over both enables; counting needs both enables
  always_comb begin
    if (!load_n)                mode = STEP_LOAD;
    else if (step_en && cin)    mode = STEP_COUNT;
    else                        mode = STEP_HOLD;
  end
endmodule

// File: rtl/bcd_next.sv
module bcd_next
  import bcd_pkg::*;
(
  input  logic [DIGIT_W-1:0] cur,
  input  logic [DIGIT_W-1:0] preset,
  input  step_mode_t         mode,
  output logic [DIGIT_W-1:0] nxt
);
  logic [DIGIT_W-1:0] incr;

  // 9 returns to 0; codes 10..15 climb and 15 wraps naturally
  always_comb begin
    if (cur == TOP_CODE) incr = '0;
    else                 incr = cur + 1'b1;
  end

  always_comb begin
    unique case (mode)
      STEP_LOAD:  nxt = preset;
      STEP_COUNT: nxt = incr;
      default:    nxt = cur;
    endcase
  end
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
  import bcd_pkg::*;
(
  input  logic               clk,
  input  logic               clr_n,
  input  logic               load_n,
  input  logic               step_en,
  input  logic               cin,
  input  logic [DIGIT_W-1:0] preset,
  output logic [DIGIT_W-1:0] q,
  output logic               tc
);
  step_mode_t         mode;
  logic [DIGIT_W-1:0] nxt;

  bcd_mode_dec u_dec (
    .load_n  (load_n),
    .step_en (step_en),
    .cin     (cin),
    .mode    (mode)
  );

  bcd_next u_next (
    .cur    (q),
    .preset (preset),
    .mode   (mode),
    .nxt    (nxt)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= nxt;
  end

  // combinational look-ahead flag
  assign tc = cin && (q == TOP_CODE);

  // R1: clear dominates clock edges
  always @(posedge clk) begin
    if (!clr_n) begin
      p_clear_hold_r1: assert (q == '0 && !tc);
    end
  end

  p_load_wins_r2: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(preset));

  p_hold_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(step_en && cin)) |=> $stable(q));

  p_wrap_nine_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && step_en && cin && q == 4'd9) |=> q == 4'd0);

  p_step_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && step_en && cin && q != 4'd9) |=> q == $past(q) + 4'd1);

  p_tc_gated_r6: assert property (@(posedge clk) disable iff (!clr_n)
    tc |-> cin);
endmodule

// File: rtl/bcd_chain.sv
module bcd_chain
  import bcd_pkg::*;
#(
  parameter int DIGITS = 3
) (
  input  logic                      clk,
  input  logic                      clr_n,
  input  logic                      load_n,
  input  logic                      step_en,
  input  logic                      carry_in,
  input  logic [DIGITS*DIGIT_W-1:0] load_data,
  output logic [DIGITS*DIGIT_W-1:0] count_out,
  output logic [DIGITS-1:0]         digit_tc,
  output logic                      chain_tc
);
  localparam int TOTAL_W = DIGITS * DIGIT_W;

  logic [DIGITS:0] carry;

  assign carry[0] = carry_in;

  for (genvar k = 0; k < DIGITS; k++) begin : g_digit
    bcd_digit u_digit (
      .clk     (clk),
      .clr_n   (clr_n),
      .load_n  (load_n),
      .step_en (step_en),
      .cin     (carry[k]),
      .preset  (load_data[k*DIGIT_W +: DIGIT_W]),
      .q       (count_out[k*DIGIT_W +: DIGIT_W]),
      .tc      (carry[k+1])
    );
    assign digit_tc[k] = carry[k+1];
  end

  assign chain_tc = carry[DIGITS];

  // R7: whole-chain flag needs the external carry-in
  p_chain_tc_r7: assert property (@(posedge clk) disable iff (!clr_n)
    chain_tc |-> (carry_in && &digit_tc));

  // R7: all-nines with a full carry rolls every digit to zero
  p_rollover_r7: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && step_en && chain_tc) |=> count_out == {TOTAL_W{1'b0}});
endmodule

// File: tb/test_bcd_chain.sv
`timescale 1ns/1ps
module test_bcd_chain;
  localparam int DIGITS = 3;
  localparam int W = DIGITS * 4;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic         load_n = 1'b1;
  logic         step_en = 1'b0;
  logic         carry_in = 1'b0;
  logic [W-1:0] load_data = '0;
  logic [W-1:0] count_out;
  logic [DIGITS-1:0] digit_tc;
  logic         chain_tc;

  int compared = 0;
  int mismatched = 0;
  logic finished = 1'b0;

  logic [3:0] mdl [DIGITS];

  always #2 clk = ~clk;

  bcd_chain #(.DIGITS(DIGITS)) i_bcd_chain (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .step_en   (step_en),
    .carry_in  (carry_in),
    .load_data (load_data),
    .count_out (count_out),
    .digit_tc  (digit_tc),
    .chain_tc  (chain_tc)
  );

  typedef struct packed {
    logic         ld_n;
    logic         ep;
    logic         et;
    logic [W-1:0] dat;
  } vec_t;

  localparam vec_t VECS [0:13] = '{
    '{1'b0, 1'b0, 1'b0, 12'h127},
    '{1'b1, 1'b1, 1'b1, 12'h000},
    '{1'b1, 1'b1, 1'b1, 12'h000},
    '{1'b1, 1'b1, 1'b1, 12'h000},
    '{1'b1, 1'b0, 1'b1, 12'h555},
    '{1'b1, 1'b1, 1'b0, 12'h555},
    '{1'b0, 1'b1, 1'b1, 12'h998},
    '{1'b1, 1'b1, 1'b1, 12'h000},
    '{1'b1, 1'b1, 1'b1, 12'h000},
    '{1'b0, 1'b1, 1'b1, 12'h0F9},
    '{1'b1, 1'b1, 1'b1, 12'h000},
    '{1'b0, 1'b0, 1'b1, 12'h199},
    '{1'b1, 1'b1, 1'b1, 12'h000},
    '{1'b1, 1'b1, 1'b0, 12'h000}
  };

  // reference model: one edge
  task automatic model_edge();
    logic t;
    logic [3:0] nq [DIGITS];
    t = carry_in;
    for (int k = 0; k < DIGITS; k++) begin
      if (!load_n)              nq[k] = load_data[k*4 +: 4];
      else if (step_en && t)    nq[k] = (mdl[k] == 4'd9) ? 4'd0 : mdl[k] + 4'd1;
      else                      nq[k] = mdl[k];
      t = t && (mdl[k] == 4'd9);
    end
    for (int k = 0; k < DIGITS; k++) mdl[k] = nq[k];
  endtask

  task automatic check(input string req);
    logic [W-1:0] eq;
    logic [DIGITS-1:0] etc;
    logic t;
    t = carry_in;
    for (int k = 0; k < DIGITS; k++) begin
      eq[k*4 +: 4] = mdl[k];
      t = t && (mdl[k] == 4'd9);
      etc[k] = t;
    end
    compared++;
    if (count_out !== eq || digit_tc !== etc || chain_tc !== etc[DIGITS-1]) begin
      mismatched++;
      $display("FAIL %s: count=%h tc=%b chain=%b expected count=%h tc=%b chain=%b",
               req, count_out, digit_tc, chain_tc, eq, etc, etc[DIGITS-1]);
    end
  endtask

  task automatic drive(input logic ld, input logic ep, input logic et, input logic [W-1:0] d);
    load_n = ld; step_en = ep; carry_in = et; load_data = d;
  endtask

  // apply at negedge, clock, check at next negedge
  task automatic cycle(input string req);
    @(posedge clk);
    if (clr_n) model_edge();
    @(negedge clk);
    check(req);
  endtask

  task automatic clear_model();
    for (int k = 0; k < DIGITS; k++) mdl[k] = 4'd0;
  endtask

  initial begin
    clear_model();
    // R1: reset state and edges ignored while clear is low
    drive(1'b0, 1'b1, 1'b1, 12'h345);
    #1;
    check("R1 reset state");
    repeat (3) cycle("R1 edges ignored under clear");

    // R8: first edge after release acts normally
    @(negedge clk);
    clr_n = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 12'h482);
    cycle("R8 first edge loads");

    // table walk: R2 R3 R4 R7
    for (int i = 0; i <= 13; i++) begin
      drive(VECS[i].ld_n, VECS[i].ep, VECS[i].et, VECS[i].dat);
      #0.5;
      check("R6 combinational flag before edge");
      cycle("R2/R3/R4/R7 table vector");
    end

    // R2: load with both enables low
    drive(1'b0, 1'b0, 1'b0, 12'h736);
    cycle("R2 load with enables low");

    // R6: digit at 9 with carry-in low gives no flag
    drive(1'b0, 1'b1, 1'b0, 12'h009);
    cycle("R2 load 009");
    drive(1'b1, 1'b1, 1'b0, 12'h000);
    #0.5;
    check("R6 carry-in low masks flag at 9");
    carry_in = 1'b1;
    #0.5;
    check("R6 flag follows carry-in");
    carry_in = 1'b0;
    cycle("R3 hold when carry-in low");

    // R5: invalid codes climb and 15 wraps
    drive(1'b0, 1'b1, 1'b1, 12'h99A);
    cycle("R5 load code 10");
    drive(1'b1, 1'b1, 1'b1, 12'h000);
    for (int s = 0; s < 6; s++) cycle("R5 invalid code step");

    // R4/R7: all nines roll over in one edge
    drive(1'b0, 1'b1, 1'b1, 12'h999);
    cycle("R7 load all nines");
    drive(1'b1, 1'b1, 1'b1, 12'h000);
    cycle("R4 R7 chain rollover");

    // R1: clear takes effect between edges
    drive(1'b0, 1'b0, 1'b0, 12'h864);
    cycle("R2 load before clear");
    #0.5;
    clr_n = 1'b0;
    clear_model();
    #0.5;
    check("R1 asynchronous clear");
    @(negedge clk);
    clr_n = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 12'h000);
    cycle("R8 count after clear");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4.0 * 200000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule